// File: doc/BRIEF.md
# Home Directory Controller

This block sits at the home node of a distributed shared-memory system and keeps coherence for a set of memory blocks that live in its local memory. For every block it holds a coherence state and a presence vector with one bit per processor. The three states are Uncached (no cached copy), Shared (one or more readers, memory current) and Exclusive (a single owner whose copy may be newer than memory). The controller takes one miss or write-back message at a time. Each message does two things: it updates the block's directory entry, and it sends the directed messages needed to satisfy the request. Those messages are data replies, invalidations, fetches, and fetch-with-invalidate commands.

Incoming requests arrive on a valid/ready port. Outgoing messages leave on two channels that can fire in the same cycle. The control channel carries a destination mask and a command. The reply channel carries one destination and a data word. When the block is held Exclusive, a miss must get the data from its owner. The controller sends the owner a fetch command and parks. It lowers its ready signal until the owner's data returns on the fetch-return port. It then writes that data to memory and forwards it to the requester. Every request is handled atomically, so no second request is taken while a fetch is outstanding.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector, every memory word is zero, `req_ready` is high, and neither `ctl_valid` nor `rsp_valid` is asserted.
- R2: A read miss (`req_type` 0) to an Uncached or Shared block produces, in the cycle after acceptance, a reply on the reply channel to the requester carrying the memory word. The requester joins the presence vector and the block becomes Shared.
- R3: A write miss (`req_type` 1) to an Uncached block produces a reply with the memory word in the cycle after acceptance. The presence vector becomes the requester alone and the block becomes Exclusive.
- R4: A write miss to a Shared block replies with the memory word. In the same cycle it issues an invalidate (`ctl_type` 1) whose mask holds every current sharer except the requester. No invalidate is issued when that mask would be empty. The block then becomes Exclusive to the requester.
- R5: A read miss to an Exclusive block issues a fetch (`ctl_type` 2) to the owner alone in the cycle after acceptance. In the cycle after the fetch return, memory takes the returned word, the requester receives it, and the block becomes Shared by both owner and requester.
- R6: A write miss to an Exclusive block issues a fetch-with-invalidate (`ctl_type` 3) to the owner alone. The returned word is forwarded to the requester and written to memory, and the requester becomes the sole owner in Exclusive.
- R7: A write-back (`req_type` 2) from the owner of an Exclusive block writes the carried word to memory and leaves the block Uncached with an empty presence vector. It sends no message.
- R8: A write-back from a processor that does not own the block, or to a block that is not Exclusive, sends no message and changes neither memory nor the directory entry.
- R9: While a fetch is outstanding, `req_ready` stays low and no request is taken. No message leaves until the fetch return arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no operation |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| req_ready | output | 1 | Controller idle and accepting |
| ctl_valid | output | 1 | Control message present |
| ctl_type | output | 2 | 1 invalidate, 2 fetch, 3 fetch-with-invalidate |
| ctl_mask | output | NPROC | Destination processors of the control message |
| ctl_blk | output | $clog2(NBLK) | Block of the control message |
| rsp_valid | output | 1 | Data reply present |
| rsp_dst | output | $clog2(NPROC) | Reply destination |
| rsp_blk | output | $clog2(NBLK) | Reply block |
| rsp_data | output | DW | Reply data |
| fetch_valid | input | 1 | Owner's data returned |
| fetch_data | input | DW | Owner's returned data |

## Verification
The bench goes after the cases where the presence vector is easy to get wrong. One is a write miss from a processor that already shares the block. A design that forgets to mask the requester would invalidate the requester's own incoming copy, or would raise an empty invalidate. Another is a read miss to an Exclusive block. Dropping the old owner from the vector would show up later as a missing invalidate to that owner. Skipping the memory update would return stale data on the next read after a write-back. Write-backs from non-owners are mixed in; a design that honours them would corrupt memory, and later replies would expose it. Extra requests are presented while a fetch is pending; a design that accepts one would answer it out of order.

// File: rtl/dir_pkg.sv
// Shared encodings for the home directory controller.
// Assumes two-bit fields for request kind, block state and control command.
package dir_pkg;
    typedef enum logic [1:0] {
        ST_UNC = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2,
        RQ_NONE  = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        CT_NONE     = 2'd0,
        CT_INV      = 2'd1,
        CT_FETCH    = 2'd2,
        CT_FETCHINV = 2'd3
    } ctl_e;
endpackage

// File: rtl/dir_entry_table.sv
// Directory storage: one state and one presence vector per block.
// One combinational read port and one synchronous write port.
// Reset clears every entry to Uncached with no sharers.
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    rd_blk,
    output dstate_e          rd_state,
    output logic [NPROC-1:0] rd_shr,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  dstate_e          wr_state,
    input  logic [NPROC-1:0] wr_shr
);
    dstate_e          st_q  [NBLK];
    logic [NPROC-1:0] shr_q [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_entry
        // Hold or update entry g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= ST_UNC;
                shr_q[g] <= '0;
            end else if (wr_en && wr_blk == BW'(g)) begin
                st_q[g]  <= wr_state;
                shr_q[g] <= wr_shr;
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_shr   = shr_q[rd_blk];
endmodule

// File: rtl/dir_data_mem.sv
// Home memory words for the tracked blocks, one word per block.
// Combinational read, synchronous write, cleared to zero on reset.
module dir_data_mem #(
    parameter int NBLK = 8,
    parameter int DW   = 16,
    localparam int BW  = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] rd_blk,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_blk,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem_q [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_word
        // Hold or update word g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en && wr_blk == BW'(g))
                mem_q[g] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_blk];
endmodule

// File: rtl/dir_decide.sv
// Pure protocol decision: given a request and the current entry, gives the
// next entry, whether a fetch from the owner is needed, the invalidate mask
// and whether memory data is replied at once. Assumes callers never send a
// miss from the current owner of an Exclusive block.
module dir_decide
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    localparam int PW   = $clog2(NPROC)
) (
    input  logic [1:0]       req_type,
    input  logic [PW-1:0]    req_src,
    input  dstate_e          cur_state,
    input  logic [NPROC-1:0] cur_shr,
    output logic             upd,
    output dstate_e          nxt_state,
    output logic [NPROC-1:0] nxt_shr,
    output logic             need_fetch,
    output logic             fetch_inv,
    output logic             reply,
    output logic             mem_wr,
    output logic [NPROC-1:0] inv_mask
);
    logic [NPROC-1:0] req_bit;
    assign req_bit = NPROC'(1) << req_src;

    // Select the transition for the request kind and current state.
    always_comb begin
        upd        = 1'b0;
        nxt_state  = cur_state;
        nxt_shr    = cur_shr;
        need_fetch = 1'b0;
        fetch_inv  = 1'b0;
        reply      = 1'b0;
        mem_wr     = 1'b0;
        inv_mask   = '0;
        case (req_type)
            RQ_READ: begin
                upd       = 1'b1;
                nxt_state = ST_SHR;
                nxt_shr   = cur_shr | req_bit;
                if (cur_state == ST_EXC) need_fetch = 1'b1;
                else                     reply      = 1'b1;
            end
            RQ_WRITE: begin
                upd       = 1'b1;
                nxt_state = ST_EXC;
                nxt_shr   = req_bit;
                if (cur_state == ST_EXC) begin
                    need_fetch = 1'b1;
                    fetch_inv  = 1'b1;
                end else begin
                    reply = 1'b1;
                    if (cur_state == ST_SHR) inv_mask = cur_shr & ~req_bit;
                end
            end
            RQ_WBACK: begin
                if (cur_state == ST_EXC && cur_shr[req_src]) begin
                    upd       = 1'b1;
                    mem_wr    = 1'b1;
                    nxt_state = ST_UNC;
                    nxt_shr   = '0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Home directory controller top. Takes one request at a time. Requests that
// need the owner's data send a fetch and park in a wait state, with ready low,
// until the fetch return arrives. All outgoing messages are registered and
// last one cycle.
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_type,
    input  logic [PW-1:0]    req_src,
    input  logic [BW-1:0]    req_blk,
    input  logic [DW-1:0]    req_data,
    output logic             req_ready,
    output logic             ctl_valid,
    output logic [1:0]       ctl_type,
    output logic [NPROC-1:0] ctl_mask,
    output logic [BW-1:0]    ctl_blk,
    output logic             rsp_valid,
    output logic [PW-1:0]    rsp_dst,
    output logic [BW-1:0]    rsp_blk,
    output logic [DW-1:0]    rsp_data,
    input  logic             fetch_valid,
    input  logic [DW-1:0]    fetch_data
);
    typedef enum logic {FS_IDLE, FS_WAIT} fsm_e;

    fsm_e             fsm_q;
    logic             accept, fetch_done;
    dstate_e          cur_state, dc_nstate, pend_state;
    logic [NPROC-1:0] cur_shr, dc_nshr, dc_inv, pend_shr;
    logic             dc_upd, dc_fetch, dc_finv, dc_reply, dc_memwr;
    logic [PW-1:0]    pend_src;
    logic [BW-1:0]    pend_blk;
    logic [DW-1:0]    mem_rd;
    logic             tbl_we, mem_we;
    logic [BW-1:0]    wr_blk;
    dstate_e          tbl_wstate;
    logic [NPROC-1:0] tbl_wshr;
    logic [DW-1:0]    mem_wdata;

    assign req_ready  = (fsm_q == FS_IDLE);
    assign accept     = req_valid && req_ready;
    assign fetch_done = (fsm_q == FS_WAIT) && fetch_valid;

    dir_entry_table #(.NPROC(NPROC), .NBLK(NBLK)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(req_blk), .rd_state(cur_state), .rd_shr(cur_shr),
        .wr_en(tbl_we), .wr_blk(wr_blk), .wr_state(tbl_wstate), .wr_shr(tbl_wshr)
    );

    dir_data_mem #(.NBLK(NBLK), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(req_blk), .rd_data(mem_rd),
        .wr_en(mem_we), .wr_blk(wr_blk), .wr_data(mem_wdata)
    );

    dir_decide #(.NPROC(NPROC)) u_decide (
        .req_type(req_type), .req_src(req_src),
        .cur_state(cur_state), .cur_shr(cur_shr),
        .upd(dc_upd), .nxt_state(dc_nstate), .nxt_shr(dc_nshr),
        .need_fetch(dc_fetch), .fetch_inv(dc_finv), .reply(dc_reply),
        .mem_wr(dc_memwr), .inv_mask(dc_inv)
    );

    // Steer the storage write ports: immediate update or fetch completion.
    always_comb begin
        wr_blk     = fetch_done ? pend_blk   : req_blk;
        tbl_wstate = fetch_done ? pend_state : dc_nstate;
        tbl_wshr   = fetch_done ? pend_shr   : dc_nshr;
        mem_wdata  = fetch_done ? fetch_data : req_data;
        tbl_we     = fetch_done || (accept && dc_upd && !dc_fetch);
        mem_we     = fetch_done || (accept && dc_memwr);
    end

    // Sequence the controller and register the outgoing messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q      <= FS_IDLE;
            ctl_valid  <= 1'b0;
            ctl_type   <= CT_NONE;
            ctl_mask   <= '0;
            ctl_blk    <= '0;
            rsp_valid  <= 1'b0;
            rsp_dst    <= '0;
            rsp_blk    <= '0;
            rsp_data   <= '0;
            pend_src   <= '0;
            pend_blk   <= '0;
            pend_state <= ST_UNC;
            pend_shr   <= '0;
        end else begin
            ctl_valid <= 1'b0;
            rsp_valid <= 1'b0;
            if (accept) begin
                ctl_blk <= req_blk;
                rsp_blk <= req_blk;
                rsp_dst <= req_src;
                if (dc_fetch) begin
                    fsm_q      <= FS_WAIT;
                    ctl_valid  <= 1'b1;
                    ctl_type   <= dc_finv ? CT_FETCHINV : CT_FETCH;
                    ctl_mask   <= cur_shr;
                    pend_src   <= req_src;
                    pend_blk   <= req_blk;
                    pend_state <= dc_nstate;
                    pend_shr   <= dc_nshr;
                end else begin
                    rsp_valid <= dc_reply;
                    rsp_data  <= mem_rd;
                    ctl_valid <= |dc_inv;
                    ctl_type  <= CT_INV;
                    ctl_mask  <= dc_inv;
                end
            end else if (fetch_done) begin
                fsm_q     <= FS_IDLE;
                rsp_valid <= 1'b1;
                rsp_dst   <= pend_src;
                rsp_blk   <= pend_blk;
                rsp_data  <= fetch_data;
            end
        end
    end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
// Protocol checker for the home directory controller, bound to its ports.
// Assumes the reply accompanying an invalidate goes to the requester.
module dir_home_ctrl_chk #(
    parameter int NPROC = 4,
    parameter int DW    = 16,
    localparam int PW   = $clog2(NPROC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             ctl_valid,
    input logic [1:0]       ctl_type,
    input logic [NPROC-1:0] ctl_mask,
    input logic             rsp_valid,
    input logic [PW-1:0]    rsp_dst,
    input logic [DW-1:0]    rsp_data,
    input logic             fetch_valid,
    input logic [DW-1:0]    fetch_data
);
    // R5 R6: fetch commands target exactly one owner
    p_fetch_single_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_type[1]) |-> ($countones(ctl_mask) == 1));

    // R4: invalidate rides with the reply and spares the requester
    p_inv_spares_requester_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_type == 2'd1) |-> (rsp_valid && !ctl_mask[rsp_dst] && ctl_mask != '0));

    // R9: a fetch leaves the controller not ready
    p_fetch_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_type[1]) |-> !req_ready);

    // R9: a waiting controller emits nothing without the fetch return
    p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !fetch_valid) |=> (!rsp_valid && !ctl_valid));

    // R5 R6: returned data is forwarded in the next cycle
    p_fetch_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && fetch_valid) |=> (rsp_valid && rsp_data == $past(fetch_data)));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NPROC(NPROC), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .ctl_valid(ctl_valid), .ctl_type(ctl_type), .ctl_mask(ctl_mask),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_data(rsp_data),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data)
);

// File: tb/dir_home_ctrl_bench.sv
// Bench: directed corners then seeded random traffic, against a bench model.
module dir_home_ctrl_bench;
    localparam int NPROC = 4;
    localparam int NBLK  = 8;
    localparam int DW    = 16;
    localparam int PW    = $clog2(NPROC);
    localparam int BW    = $clog2(NBLK);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [1:0] req_type = 0;
    logic [PW-1:0] req_src = 0;
    logic [BW-1:0] req_blk = 0;
    logic [DW-1:0] req_data = 0;
    logic req_ready, ctl_valid, rsp_valid;
    logic [1:0] ctl_type;
    logic [NPROC-1:0] ctl_mask;
    logic [BW-1:0] ctl_blk, rsp_blk;
    logic [PW-1:0] rsp_dst;
    logic [DW-1:0] rsp_data;
    logic fetch_valid = 0;
    logic [DW-1:0] fetch_data = 0;

    int nchk = 0, nerr = 0;
    bit done = 0;

    logic [1:0]       m_st  [NBLK];
    logic [NPROC-1:0] m_sh  [NBLK];
    logic [DW-1:0]    m_mem [NBLK];
    logic [DW-1:0]    m_own [NBLK];

    always #10 clk = ~clk;

    dir_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_dir_home_ctrl (.*);

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [NPROC-1:0] bit_of(input int p);
        return NPROC'(1) << p;
    endfunction

    // Issue one request, check its messages, and update the model.
    task automatic do_req(input int kind, input int src, input int blk, input logic [DW-1:0] data);
        logic [1:0] st = m_st[blk];
        logic [NPROC-1:0] sh = m_sh[blk];
        logic [NPROC-1:0] inv;
        string rq;
        @(negedge clk);
        req_valid = 1; req_type = 2'(kind); req_src = PW'(src);
        req_blk = BW'(blk); req_data = data;
        @(negedge clk);
        req_valid = 0;
        if (kind != 2 && st == 2'd2) begin
            rq = (kind == 0) ? "R5" : "R6";
            check(rq, "ctl_valid", ctl_valid, 1);
            check(rq, "ctl_type", ctl_type, kind == 0 ? 2 : 3);
            check(rq, "ctl_mask", ctl_mask, sh);
            check(rq, "ctl_blk", ctl_blk, blk);
            check("R9", "req_ready low", req_ready, 0);
            for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
                req_valid = 1; req_type = 2'($urandom_range(0, 2));
                req_src = PW'($urandom_range(0, NPROC-1)); req_blk = BW'($urandom_range(0, NBLK-1));
                @(negedge clk);
                req_valid = 0;
                check("R9", "deferred ready", req_ready, 0);
                check("R9", "no reply", rsp_valid, 0);
                check("R9", "no ctl", ctl_valid, 0);
            end
            fetch_valid = 1; fetch_data = m_own[blk];
            @(negedge clk);
            fetch_valid = 0;
            check(rq, "rsp_valid", rsp_valid, 1);
            check(rq, "rsp_dst", rsp_dst, src);
            check(rq, "rsp_blk", rsp_blk, blk);
            check(rq, "rsp_data", rsp_data, m_own[blk]);
            check(rq, "ctl quiet", ctl_valid, 0);
            m_mem[blk] = m_own[blk];
            if (kind == 0) begin
                m_sh[blk] = sh | bit_of(src); m_st[blk] = 2'd1;
            end else begin
                m_sh[blk] = bit_of(src); m_st[blk] = 2'd2; m_own[blk] = DW'($urandom);
            end
        end else if (kind == 2) begin
            rq = (st == 2'd2 && sh[src]) ? "R7" : "R8";
            check(rq, "no reply", rsp_valid, 0);
            check(rq, "no ctl", ctl_valid, 0);
            if (rq == "R7") begin
                m_mem[blk] = data; m_st[blk] = 2'd0; m_sh[blk] = '0;
            end
        end else begin
            rq = (kind == 0) ? "R2" : (st == 2'd1 ? "R4" : "R3");
            inv = (kind == 1 && st == 2'd1) ? (sh & ~bit_of(src)) : '0;
            check(rq, "rsp_valid", rsp_valid, 1);
            check(rq, "rsp_dst", rsp_dst, src);
            check(rq, "rsp_blk", rsp_blk, blk);
            check(rq, "rsp_data", rsp_data, m_mem[blk]);
            check(rq, "ctl_valid", ctl_valid, inv != '0);
            if (inv != '0) begin
                check(rq, "ctl_type", ctl_type, 1);
                check(rq, "ctl_mask", ctl_mask, inv);
            end
            if (kind == 0) begin
                m_sh[blk] = sh | bit_of(src); m_st[blk] = 2'd1;
            end else begin
                m_sh[blk] = bit_of(src); m_st[blk] = 2'd2; m_own[blk] = DW'($urandom);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NBLK; b++) begin
            m_st[b] = 0; m_sh[b] = 0; m_mem[b] = 0; m_own[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", "req_ready", req_ready, 1);
        check("R1", "ctl_valid", ctl_valid, 0);
        check("R1", "rsp_valid", rsp_valid, 0);
        // Directed corners.
        do_req(0, 1, 0, 0);            // R2 read from Uncached: memory zero
        do_req(0, 3, 0, 0);            // R2 second reader joins
        do_req(1, 1, 0, 0);            // R4 requester already sharer: only P3 invalidated
        do_req(2, 0, 0, 16'h1111);     // R8 write-back from non-owner ignored
        do_req(0, 2, 0, 0);            // R5 fetch from owner P1
        do_req(1, 2, 0, 0);            // R4 invalidate P1 only
        do_req(1, 0, 0, 0);            // R6 fetch-invalidate from P2
        do_req(2, 0, 0, 16'hBEEF);     // R7 owner write-back
        do_req(0, 3, 0, 0);            // R2 sees written-back data
        do_req(1, 2, 5, 0);            // R3 write miss to Uncached
        do_req(2, 1, 3, 16'h2222);     // R8 write-back to Uncached ignored
        do_req(0, 1, 3, 0);            // R2 memory still zero
        do_req(1, 1, 3, 0);            // R4 sole sharer upgrades: no invalidate
        // Seeded random traffic.
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 2);
            int s = $urandom_range(0, NPROC-1);
            int b = $urandom_range(0, NBLK-1);
            logic [DW-1:0] d = DW'($urandom);
            if (m_st[b] == 2'd2 && m_sh[b][s]) begin
                k = 2; d = m_own[b];
            end
            do_req(k, s, b, d);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule